// File: doc/BRIEF.md
# Parallel Code Search Controller

This block steers acquisition and tracking of a periodic spreading code for a receiver that runs a bank of correlation detectors side by side, each one half a chip later than its neighbour. On every symbol strobe it receives one coherent I/Q sum per detector. It squares each sum into an energy and adds it up over a block of symbols. At the end of each block it takes one decision and issues it as a signed code phase adjustment in half-chip bins. The code generator applies that adjustment to the replica that feeds the detector bank.

While searching, the controller moves the detector window through the code period one window width at a time until one bin clearly stands out above the mean of the window. It then centres that bin and declares code lock. Once locked, three detectors around the centre act as early, on-time and late taps, and the sign of the early/late energy difference gives a one-bin nudge. The remaining detectors are moved away from the tracked point by a scan offset, which the controller also outputs, and they look for a stronger correlation elsewhere in the code. If a scanning detector beats the on-time tap by a programmable factor in two blocks in a row, the lock is treated as false. Lock is then dropped, a restart event is raised, and search resumes at the offending offset.

The control is a three-state machine. ST_SEARCH moves to ST_TRACK on a hit and stays in ST_SEARCH with a window step on a miss. ST_TRACK stays in ST_TRACK when no scanner exceeds the margin and moves to ST_SUSPECT when one does. ST_SUSPECT returns to ST_TRACK on a clean block and goes to ST_SEARCH (false lock) on a second exceeding block. Decisions are taken only in the cycle after a block completes.

Top module: `pcs_code_search`

## Requirements
- R1: After reset, code_lock, phase_adj_vld and false_lock are 0, the state is ST_SEARCH and scan_off equals N_DET modulo CODE_BINS.
- R2: Detector energy is I*I+Q*Q of the signed SUM_W-bit inputs, summed over AVG_LEN strobes. No decision output (phase_adj_vld or false_lock) appears before the AVG_LEN-th strobe of a block.
- R3: In ST_SEARCH, a block whose best energy E_max fails the hit test gives phase_adj = +N_DET and code_lock stays 0.
- R4: The hit test is 16*N_DET*E_max > hit_thr*E_total, with hit_thr an unsigned value carrying 4 fractional bits. On a hit, phase_adj = best_index - N_DET/2 and code_lock rises in the same cycle. On an energy tie, the lowest detector index wins.
- R5: While locked, detectors N_DET/2-1, N_DET/2 and N_DET/2+1 are early, on-time and late. Early energy greater than late energy gives phase_adj = -1, late greater than early gives +1, and equal energies give no phase_adj_vld pulse.
- R6: On lock, scan_off is set to N_DET mod CODE_BINS. It then advances by N_DET modulo CODE_BINS after each locked block in which no scanner exceeds the margin, and it does not change while unlocked.
- R7: A scanner exceeds the margin when 16*E_scan > fl_margin*E_ontime (fl_margin with 4 fractional bits). A single exceeding block keeps code_lock high, holds scan_off and raises no false_lock.
- R8: A second consecutive exceeding block pulses false_lock, drops code_lock, and gives phase_adj = k - N_DET/2 + scan_off, where k is the strongest exceeding scanner (lowest index on a tie).
- R9: phase_adj_vld and false_lock are one-cycle pulses. They are high in the second cycle after the clock edge that samples the block's final strobe, and only after a completed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_stb | input | 1 | Symbol strobe; det_i/det_q valid |
| det_i | input | N_DET*SUM_W | Per-detector signed coherent in-phase sums, detector k at bits k*SUM_W |
| det_q | input | N_DET*SUM_W | Per-detector signed coherent quadrature sums |
| hit_thr | input | TH_W | Search hit factor over the window mean, 4 fractional bits |
| fl_margin | input | TH_W | False-lock factor over on-time energy, 4 fractional bits |
| phase_adj | output | ADJ_W | Signed code phase command in half-chip bins |
| phase_adj_vld | output | 1 | phase_adj is valid this cycle |
| code_lock | output | 1 | Code lock indication |
| false_lock | output | 1 | False-lock restart event |
| scan_off | output | OFS_W | Extra delay in bins applied to the scanning detectors |

## Verification
A wrong state or energy sum becomes visible at the ports at the next block boundary, two cycles after the final strobe: the phase command takes a wrong sign or size, or code_lock changes on the wrong block. A wrong scan offset shows up immediately on scan_off, and a lost ST_SUSPECT memory shows up one block later as a missing or early false_lock. The bench drives random and directed per-detector amplitudes, predicts every block decision from its own energy sums, and also checks that nothing is issued before a block has completed.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_TRACK   = 2'd1,
        ST_SUSPECT = 2'd2
    } pcs_state_e;
endpackage

// File: rtl/pcs_energy_acc.sv
module pcs_energy_acc #(
    parameter int N_DET   = 30,
    parameter int SUM_W   = 12,
    parameter int AVG_LEN = 100,
    parameter int ACC_W   = 31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sym_stb,
    input  logic [N_DET*SUM_W-1:0]   det_i,
    input  logic [N_DET*SUM_W-1:0]   det_q,
    output logic                     blk_rdy,
    output logic [N_DET*ACC_W-1:0]   blk_sum
);
    localparam int E_W   = 2 * SUM_W;
    localparam int CNT_W = (AVG_LEN > 1) ? $clog2(AVG_LEN) : 1;

    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last = (cnt == CNT_W'(AVG_LEN - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            blk_rdy <= 1'b0;
        end else begin
            blk_rdy <= sym_stb & last;
            if (sym_stb) begin
                cnt <= last ? '0 : cnt + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N_DET; g++) begin : g_det
        logic signed [SUM_W-1:0] si;
        logic signed [SUM_W-1:0] sq;
        logic signed [E_W-1:0]   pi;
        logic signed [E_W-1:0]   pq;
        logic [E_W-1:0]          nrg;
        logic [ACC_W-1:0]        acc;
        logic [ACC_W-1:0]        snap;

        assign si  = det_i[g*SUM_W +: SUM_W];
        assign sq  = det_q[g*SUM_W +: SUM_W];
        assign pi  = E_W'(si) * E_W'(si);
        assign pq  = E_W'(sq) * E_W'(sq);
        assign nrg = $unsigned(pi) + $unsigned(pq);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc  <= '0;
                snap <= '0;
            end else if (sym_stb) begin
                if (last) begin
                    snap <= acc + ACC_W'(nrg);
                    acc  <= '0;
                end else begin
                    acc  <= acc + ACC_W'(nrg);
                end
            end
        end

        assign blk_sum[g*ACC_W +: ACC_W] = snap;
    end
endmodule

// File: rtl/pcs_block_eval.sv
module pcs_block_eval #(
    parameter int N_DET = 30,
    parameter int ACC_W = 31,
    parameter int TH_W  = 8,
    parameter int CTR   = 15
) (
    input  logic [N_DET*ACC_W-1:0]      blk_sum,
    input  logic [TH_W-1:0]             hit_thr,
    input  logic [TH_W-1:0]             fl_margin,
    output logic                        hit,
    output logic [$clog2(N_DET)-1:0]    best_idx,
    output logic                        early_gt,
    output logic                        late_gt,
    output logic                        exc_any,
    output logic [$clog2(N_DET)-1:0]    exc_idx
);
    localparam int IDX_W = $clog2(N_DET);
    localparam int TOT_W = ACC_W + $clog2(N_DET) + 1;
    localparam int CMP_W = ACC_W + $clog2(N_DET) + TH_W + 6;

    logic [ACC_W-1:0] s [N_DET];
    logic [ACC_W-1:0] best_v;
    logic [ACC_W-1:0] exc_v;
    logic [TOT_W-1:0] total;
    logic [CMP_W-1:0] peak_lhs;
    logic [CMP_W-1:0] peak_rhs;
    logic [CMP_W-1:0] ontime_lim;

    for (genvar g = 0; g < N_DET; g++) begin : g_unpack
        assign s[g] = blk_sum[g*ACC_W +: ACC_W];
    end

    // Peak and total over the whole window; strict compare keeps the lowest index on ties.
    always_comb begin
        best_v   = s[0];
        best_idx = '0;
        total    = '0;
        for (int k = 0; k < N_DET; k++) begin
            total = total + TOT_W'(s[k]);
            if (k > 0 && s[k] > best_v) begin
                best_v   = s[k];
                best_idx = IDX_W'(k);
            end
        end
    end

    assign peak_lhs = CMP_W'(best_v) * CMP_W'(16 * N_DET);
    assign peak_rhs = CMP_W'(hit_thr) * CMP_W'(total);
    assign hit      = peak_lhs > peak_rhs;

    assign early_gt = s[CTR-1] > s[CTR+1];
    assign late_gt  = s[CTR+1] > s[CTR-1];

    assign ontime_lim = CMP_W'(fl_margin) * CMP_W'(s[CTR]);

    // Scanning detectors: all bins outside the early/on-time/late triple.
    always_comb begin
        exc_any = 1'b0;
        exc_idx = '0;
        exc_v   = '0;
        for (int k = 0; k < N_DET; k++) begin
            if (k < CTR - 1 || k > CTR + 1) begin
                if ((CMP_W'(s[k]) << 4) > ontime_lim) begin
                    if (!exc_any || s[k] > exc_v) begin
                        exc_any = 1'b1;
                        exc_idx = IDX_W'(k);
                        exc_v   = s[k];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pcs_scan_step.sv
module pcs_scan_step #(
    parameter int N_DET     = 30,
    parameter int CODE_BINS = 4094,
    parameter int OFS_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    output logic [OFS_W-1:0] scan_off
);
    localparam int W1   = OFS_W + 1;
    localparam int STEP = N_DET % CODE_BINS;

    logic [W1-1:0]    raw;
    logic [OFS_W-1:0] stepped;

    assign raw     = {1'b0, scan_off} + W1'(STEP);
    assign stepped = (raw >= W1'(CODE_BINS)) ? OFS_W'(raw - W1'(CODE_BINS)) : OFS_W'(raw);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_off <= OFS_W'(STEP);
        end else if (load) begin
            scan_off <= OFS_W'(STEP);
        end else if (adv) begin
            scan_off <= stepped;
        end
    end
endmodule

// File: rtl/pcs_code_search.sv
module pcs_code_search
    import pcs_pkg::*;
#(
    parameter int  N_DET     = 30,
    parameter int  SUM_W     = 12,
    parameter int  AVG_LEN   = 100,
    parameter int  CODE_BINS = 4094,
    parameter int  TH_W      = 8,
    localparam int OFS_W     = $clog2(CODE_BINS),
    localparam int ADJ_W     = $clog2(CODE_BINS + N_DET) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_stb,
    input  logic [N_DET*SUM_W-1:0]  det_i,
    input  logic [N_DET*SUM_W-1:0]  det_q,
    input  logic [TH_W-1:0]         hit_thr,
    input  logic [TH_W-1:0]         fl_margin,
    output logic signed [ADJ_W-1:0] phase_adj,
    output logic                    phase_adj_vld,
    output logic                    code_lock,
    output logic                    false_lock,
    output logic [OFS_W-1:0]        scan_off
);
    localparam int ACC_W = 2 * SUM_W + $clog2(AVG_LEN + 1);
    localparam int IDX_W = $clog2(N_DET);
    localparam int CTR   = N_DET / 2;

    pcs_state_e st, st_nxt;

    logic                    blk_rdy;
    logic [N_DET*ACC_W-1:0]  blk_sum;
    logic                    hit;
    logic [IDX_W-1:0]        best_idx;
    logic                    early_gt;
    logic                    late_gt;
    logic                    exc_any;
    logic [IDX_W-1:0]        exc_idx;
    logic                    scan_load;
    logic                    scan_adv;
    logic                    n_vld;
    logic                    n_fl;
    logic [ADJ_W-1:0]        n_adj;

    pcs_energy_acc #(
        .N_DET   (N_DET),
        .SUM_W   (SUM_W),
        .AVG_LEN (AVG_LEN),
        .ACC_W   (ACC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sym_stb (sym_stb),
        .det_i   (det_i),
        .det_q   (det_q),
        .blk_rdy (blk_rdy),
        .blk_sum (blk_sum)
    );

    pcs_block_eval #(
        .N_DET (N_DET),
        .ACC_W (ACC_W),
        .TH_W  (TH_W),
        .CTR   (CTR)
    ) u_eval (
        .blk_sum   (blk_sum),
        .hit_thr   (hit_thr),
        .fl_margin (fl_margin),
        .hit       (hit),
        .best_idx  (best_idx),
        .early_gt  (early_gt),
        .late_gt   (late_gt),
        .exc_any   (exc_any),
        .exc_idx   (exc_idx)
    );

    pcs_scan_step #(
        .N_DET     (N_DET),
        .CODE_BINS (CODE_BINS),
        .OFS_W     (OFS_W)
    ) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (scan_load),
        .adv      (scan_adv),
        .scan_off (scan_off)
    );

    // Next state and next outputs, evaluated once per completed block.
    always_comb begin
        st_nxt    = st;
        n_vld     = 1'b0;
        n_fl      = 1'b0;
        n_adj     = '0;
        scan_load = 1'b0;
        scan_adv  = 1'b0;
        if (blk_rdy) begin
            unique case (st)
                ST_SEARCH: begin
                    n_vld = 1'b1;
                    if (hit) begin
                        st_nxt    = ST_TRACK;
                        n_adj     = ADJ_W'(int'(best_idx) - CTR);
                        scan_load = 1'b1;
                    end else begin
                        n_adj = ADJ_W'(N_DET);
                    end
                end
                ST_TRACK, ST_SUSPECT: begin
                    if (exc_any && st == ST_SUSPECT) begin
                        st_nxt = ST_SEARCH;
                        n_fl   = 1'b1;
                        n_vld  = 1'b1;
                        n_adj  = ADJ_W'(int'(exc_idx) - CTR + int'(scan_off));
                    end else begin
                        if (exc_any) begin
                            st_nxt = ST_SUSPECT;
                        end else begin
                            st_nxt   = ST_TRACK;
                            scan_adv = 1'b1;
                        end
                        if (early_gt) begin
                            n_vld = 1'b1;
                            n_adj = '1;
                        end else if (late_gt) begin
                            n_vld = 1'b1;
                            n_adj = ADJ_W'(1);
                        end
                    end
                end
                default: st_nxt = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_SEARCH;
        end else begin
            st <= st_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_adj     <= '0;
            phase_adj_vld <= 1'b0;
            false_lock    <= 1'b0;
        end else begin
            phase_adj_vld <= n_vld;
            false_lock    <= n_fl;
            if (n_vld) begin
                phase_adj <= n_adj;
            end
        end
    end

    assign code_lock = (st != ST_SEARCH);
endmodule

// File: rtl/pcs_code_search_chk.sv
module pcs_code_search_chk #(
    parameter int ADJ_W     = 13,
    parameter int OFS_W     = 12,
    parameter int CODE_BINS = 4094
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    blk_rdy,
    input logic signed [ADJ_W-1:0] phase_adj,
    input logic                    phase_adj_vld,
    input logic                    code_lock,
    input logic                    false_lock,
    input logic [OFS_W-1:0]        scan_off
);
    AST_VLD_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        phase_adj_vld |-> $past(blk_rdy)); // R9

    AST_FL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        false_lock |=> !false_lock); // R9

    AST_FL_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        false_lock |-> (!code_lock && $past(code_lock))); // R8

    AST_LOCK_WITH_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_lock) |-> phase_adj_vld); // R4

    AST_NUDGE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_adj_vld && code_lock && $past(code_lock)) |->
            (phase_adj == ADJ_W'(1) || phase_adj == '1)); // R5

    AST_SCAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_off < OFS_W'(CODE_BINS)); // R6

    AST_SCAN_HOLD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_lock && !$past(code_lock)) |-> $stable(scan_off)); // R6
endmodule

bind pcs_code_search pcs_code_search_chk #(
    .ADJ_W     (ADJ_W),
    .OFS_W     (OFS_W),
    .CODE_BINS (CODE_BINS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .blk_rdy       (blk_rdy),
    .phase_adj     (phase_adj),
    .phase_adj_vld (phase_adj_vld),
    .code_lock     (code_lock),
    .false_lock    (false_lock),
    .scan_off      (scan_off)
);

// File: tb/test_pcs_code_search.sv
`timescale 1ns/1ps
module test_pcs_code_search;
    localparam int N_DET     = 30;
    localparam int SUM_W     = 8;
    localparam int AVG_LEN   = 4;
    localparam int CODE_BINS = 100;
    localparam int TH_W      = 8;
    localparam int OFS_W     = $clog2(CODE_BINS);
    localparam int ADJ_W     = $clog2(CODE_BINS + N_DET) + 1;
    localparam int CTR       = N_DET / 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    sym_stb = 1'b0;
    logic [N_DET*SUM_W-1:0]  det_i = '0;
    logic [N_DET*SUM_W-1:0]  det_q = '0;
    logic [TH_W-1:0]         hit_thr = 8'd64;
    logic [TH_W-1:0]         fl_margin = 8'd32;
    logic signed [ADJ_W-1:0] phase_adj;
    logic                    phase_adj_vld;
    logic                    code_lock;
    logic                    false_lock;
    logic [OFS_W-1:0]        scan_off;

    int     checks = 0;
    int     errors = 0;
    bit     done   = 0;
    longint esum [N_DET];
    int     pat  [N_DET];
    int     ms    = 0;               // 0 search, 1 track, 2 suspect
    int     mscan = N_DET % CODE_BINS;

    always #4 clk = ~clk;

    pcs_code_search #(
        .N_DET (N_DET), .SUM_W (SUM_W), .AVG_LEN (AVG_LEN),
        .CODE_BINS (CODE_BINS), .TH_W (TH_W)
    ) i_pcs_code_search (
        .clk (clk), .rst_n (rst_n), .sym_stb (sym_stb),
        .det_i (det_i), .det_q (det_q),
        .hit_thr (hit_thr), .fl_margin (fl_margin),
        .phase_adj (phase_adj), .phase_adj_vld (phase_adj_vld),
        .code_lock (code_lock), .false_lock (false_lock),
        .scan_off (scan_off)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int jitter(input int j);
        if (j == 0) return 0;
        return int'($urandom_range(2 * j, 0)) - j;
    endfunction

    function automatic void fill(input int base);
        for (int k = 0; k < N_DET; k++) pat[k] = base;
    endfunction

    // Bench prediction of one block decision from its own energy sums.
    task automatic predict(output bit ev, output int eadj, output bit efl,
                           output string tadj, output string tscan);
        longint best = esum[0];
        int     bi   = 0;
        longint tot  = 0;
        ev = 0; eadj = 0; efl = 0; tscan = "R6";
        for (int k = 0; k < N_DET; k++) begin
            tot += esum[k];
            if (esum[k] > best) begin best = esum[k]; bi = k; end
        end
        if (ms == 0) begin
            ev = 1;
            if (longint'(16 * N_DET) * best > longint'(hit_thr) * tot) begin
                tadj = "R4"; eadj = bi - CTR; ms = 1; mscan = N_DET % CODE_BINS;
            end else begin
                tadj = "R3"; eadj = N_DET;
            end
        end else begin
            longint c   = esum[CTR];
            bit     any = 0;
            int     oi  = 0;
            longint ov  = 0;
            for (int k = 0; k < N_DET; k++) begin
                if (k < CTR - 1 || k > CTR + 1) begin
                    if (16 * esum[k] > longint'(fl_margin) * c && (!any || esum[k] > ov)) begin
                        any = 1; oi = k; ov = esum[k];
                    end
                end
            end
            if (any && ms == 2) begin
                tadj = "R8"; ev = 1; efl = 1; eadj = oi - CTR + mscan; ms = 0;
            end else begin
                tadj = "R5";
                if (esum[CTR-1] > esum[CTR+1]) begin ev = 1; eadj = -1; end
                else if (esum[CTR+1] > esum[CTR-1]) begin ev = 1; eadj = 1; end
                if (any) begin ms = 2; tscan = "R7"; end
                else begin ms = 1; mscan = (mscan + N_DET) % CODE_BINS; end
            end
        end
    endtask

    task automatic run_block(input int jit);
        bit    early = 0;
        bit    ev, efl, gv, gfl, gl;
        int    eadj, gadj, gscan;
        string tadj, tscan;
        for (int k = 0; k < N_DET; k++) esum[k] = 0;
        for (int s = 0; s < AVG_LEN; s++) begin
            @(negedge clk);
            if (phase_adj_vld || false_lock) early = 1;
            for (int k = 0; k < N_DET; k++) begin
                int iv = pat[k] + jitter(jit);
                int qv = jitter(jit);
                if (iv > 127) iv = 127;
                if (iv < -128) iv = -128;
                det_i[k*SUM_W +: SUM_W] = SUM_W'(iv);
                det_q[k*SUM_W +: SUM_W] = SUM_W'(qv);
                esum[k] += longint'(iv * iv + qv * qv);
            end
            sym_stb = 1'b1;
            @(negedge clk);
            sym_stb = 1'b0;
            if (s < AVG_LEN - 1) begin
                if (phase_adj_vld || false_lock) early = 1;
                repeat (2) begin
                    @(negedge clk);
                    if (phase_adj_vld || false_lock) early = 1;
                end
            end
        end
        chk(!early, "R2", "pulse before block end", early, 0);
        chk(!phase_adj_vld, "R9", "vld one cycle after last strobe", phase_adj_vld, 0);
        @(negedge clk);
        gv = phase_adj_vld; gfl = false_lock; gl = code_lock;
        gadj = int'(phase_adj); gscan = int'(scan_off);
        @(negedge clk);
        chk(!phase_adj_vld && !false_lock, "R9", "pulse width", phase_adj_vld, 0);
        predict(ev, eadj, efl, tadj, tscan);
        chk(gv == ev, tadj, "phase_adj_vld", gv, ev);
        if (ev) chk(gadj == eadj, tadj, "phase_adj", gadj, eadj);
        chk(gfl == efl, "R8", "false_lock", gfl, efl);
        chk(gl == (ms != 0), (tadj == "R8") ? "R8" : "R4", "code_lock", gl, (ms != 0));
        chk(gscan == mscan, tscan, "scan_off", gscan, mscan);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(code_lock == 0 && phase_adj_vld == 0 && false_lock == 0, "R1",
            "outputs in reset", {code_lock, phase_adj_vld, false_lock}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(scan_off == OFS_W'(N_DET % CODE_BINS), "R1", "scan_off after reset",
            scan_off, N_DET % CODE_BINS);
        chk(!code_lock, "R1", "lock after reset", code_lock, 0);

        // R3: flat window misses
        fill(20); run_block(2);
        // R4: single strong bin at 22 gives jump of +7
        fill(10); pat[22] = 100; run_block(0);
        // R5: early stronger, then late stronger, then equal (scan wraps, R6)
        fill(10); pat[15] = 100; pat[14] = 60; pat[16] = 40; run_block(0);
        fill(10); pat[15] = 100; pat[14] = 40; pat[16] = 60; run_block(0);
        fill(10); pat[15] = 100; pat[14] = 50; pat[16] = 50; run_block(0);
        // R7: one exceeding block, then a clean block
        fill(10); pat[15] = 40; pat[14] = 30; pat[16] = 20; pat[3] = 100; run_block(0);
        fill(10); pat[15] = 100; pat[14] = 60; pat[16] = 40; run_block(0);
        // R8: two exceeding blocks in a row
        fill(10); pat[15] = 40; pat[14] = 30; pat[16] = 20; pat[3] = 100; run_block(0);
        fill(10); pat[15] = 40; pat[14] = 30; pat[16] = 20; pat[3] = 100; run_block(0);
        // R4: tie between bins 4 and 9, lowest index wins
        fill(5); pat[4] = 90; pat[9] = 90; run_block(0);

        // Random blocks with random thresholds
        for (int b = 0; b < 60; b++) begin
            hit_thr   = TH_W'($urandom_range(80, 16));
            fl_margin = TH_W'($urandom_range(48, 16));
            for (int k = 0; k < N_DET; k++) pat[k] = int'($urandom_range(40, 0));
            if ($urandom_range(9, 0) < 6) pat[$urandom_range(N_DET - 1, 0)] = int'($urandom_range(127, 90));
            if ($urandom_range(9, 0) < 5) pat[CTR] = int'($urandom_range(127, 60));
            run_block(int'($urandom_range(4, 0)));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule